// File: doc/BRIEF.md
# PCI Master Request Word Sequencer

This block sits between application logic and an embedded PCI master core. It turns one transaction request into the serial stream of 18-bit request words that the core's request port takes in. A request carries a PCI command code, a 32-bit start address, a burst length, read byte enables, a direction, a dual-address flag, a holding-register select, a same-previous-burst-length flag and a single-transfer flag. The block accepts a request only while it is idle.

Once it has a request, the sequencer sends a command word, then a burst-length word for reads only, then the low half and then the high half of the address. A word moves only in a cycle in which the core reports room and readiness. Each word that moves is marked by an enable strobe, and the high address half also carries the last-cycle marker. A write that starts on an odd 32-bit address is followed by one padding data word, so that later write data lines up with 64-bit FIFO slots. The padding is left out for a single transfer to a 32-bit agent.

Top module: `pci_req_seq`

## Requirements
- R1: A word (request or padding) is transferred only in a cycle with `core_ready_i`=1 and `core_full_i`=0. In any other cycle `word_en_o` and `data_en_o` stay low and `word_o` keeps its value.
- R2: Words leave in this order: command word, then the burst-length word (reads only), then the low address half, then the high address half. `last_o` is 1 only with the high address half.
- R3: The command word has bit 17 = same-previous-burst-length flag, bit 16 = dual-address flag, bits 15:13 = 0, bit 12 = holding-register select (0 or 1), bits 11:4 = read byte enables and bits 3:0 = command code.
- R4: For a write (`req_write_i`=1), command word bits 17 and 11:4 are zero, whatever `req_spl_i` and `req_be_i` hold.
- R5: A read sends a burst-length word whose bits 17:0 equal `req_blen_i`. A write sends none.
- R6: The low address word carries address bits 15:0 and the high address word carries address bits 31:16, each in bits 15:0, with bits 17:16 zero.
- R7: A padding word follows the address words exactly when the request is a write with address bit 2 set, and either `agent64_i`=1 or `req_single_i`=0. A read, an even-address write, or an odd single write to a 32-bit agent gets no padding.
- R8: The padding word is signalled by `data_en_o` with `word_o`=0 and `dbe_n_o`=8'hFF (all active-low byte enables off). It comes after the high address word and obeys R1.
- R9: `req_ready_o` is 1 only when idle. After a request is accepted, `busy_o` stays 1 until the final request or padding word has been transferred.
- R10: After reset the block is idle: `req_ready_o`=1, `busy_o`=0, `word_en_o`=0, `data_en_o`=0, `last_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| agent64_i | input | 1 | Target agent is 64-bit |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request taken this cycle when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cmd_i | input | 4 | PCI command code |
| req_addr_i | input | 32 | Start address |
| req_blen_i | input | 18 | Read burst length in 64-bit words |
| req_be_i | input | 8 | Read byte enables |
| req_dac_i | input | 1 | Dual-address flag |
| req_hr_i | input | 1 | Holding-register select |
| req_spl_i | input | 1 | Same-previous-burst-length flag |
| req_single_i | input | 1 | Single 32-bit transfer |
| core_ready_i | input | 1 | Core ready for a word |
| core_full_i | input | 1 | Core FIFO full |
| word_o | output | 18 | Request or padding word |
| word_en_o | output | 1 | Request word transferred |
| last_o | output | 1 | Final word of command/address phase |
| data_en_o | output | 1 | Padding data word transferred |
| dbe_n_o | output | 8 | Active-low byte enables of the data word |
| busy_o | output | 1 | Request in progress |

## Verification
The assertions check, on every cycle, that no strobe fires without core room (R1), that a stalled word holds steady (R1), that `last_o` comes only with a word enable (R2), that the two strobes never fire together, and that an accept makes the block busy (R9). Field layout, the direction-specific rules, word order, the padding decision across agent width and transfer size, and the `busy_o` span can only be shown by the bench's scenarios. It runs these under random stalls against a queue-based model.

// File: rtl/pci_req_seq_pkg.sv
package pci_req_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_BLEN = 3'd2,
    ST_ALO  = 3'd3,
    ST_AHI  = 3'd4,
    ST_PAD  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/pci_req_cmd_fmt.sv
module pci_req_cmd_fmt #(
  parameter int WORD_W = 18,
  parameter int BE_W   = 8,
  parameter int CMD_W  = 4
) (
  input  logic              write_i,
  input  logic              spl_i,
  input  logic              dac_i,
  input  logic              hr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int PAD_W = WORD_W - 3 - BE_W - CMD_W;

  // writes clear spl and byte-enable fields
  always_comb begin
    word_o = {spl_i & ~write_i, dac_i, {PAD_W{1'b0}}, hr_i,
              be_i & {BE_W{~write_i}}, cmd_i};
  end
endmodule

// File: rtl/pci_req_fsm.sv
module pci_req_fsm
  import pci_req_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       go_i,
  input  logic       is_read_i,
  input  logic       need_pad_i,
  output seq_state_e state_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_CMD;
      ST_CMD:  if (go_i) st_d = is_read_i ? ST_BLEN : ST_ALO;
      ST_BLEN: if (go_i) st_d = ST_ALO;
      ST_ALO:  if (go_i) st_d = ST_AHI;
      ST_AHI:  if (go_i) st_d = need_pad_i ? ST_PAD : ST_IDLE;
      ST_PAD:  if (go_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  a_r9_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i) |=> (st_q == ST_CMD));
endmodule

// File: rtl/pci_req_seq.sv
module pci_req_seq
  import pci_req_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 18,
  parameter int BE_W   = 8,
  parameter int CMD_W  = 4,
  parameter int ODD_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              agent64_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [CMD_W-1:0]  req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] req_blen_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic              req_dac_i,
  input  logic              req_hr_i,
  input  logic              req_spl_i,
  input  logic              req_single_i,
  input  logic              core_ready_i,
  input  logic              core_full_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_en_o,
  output logic              last_o,
  output logic              data_en_o,
  output logic [BE_W-1:0]   dbe_n_o,
  output logic              busy_o
);
  localparam int HALF_W = ADDR_W / 2;
  localparam int HI_PAD = WORD_W - HALF_W;

  logic [WORD_W-1:0] cmd_word_q, blen_q;
  logic [ADDR_W-1:0] addr_q;
  logic              read_q, pad_q;
  logic [WORD_W-1:0] cmd_word;
  logic              start, go;
  seq_state_e        state;

  assign start = req_valid_i && req_ready_o;
  assign go    = core_ready_i && !core_full_i;

  pci_req_cmd_fmt #(.WORD_W(WORD_W), .BE_W(BE_W), .CMD_W(CMD_W)) u_fmt (
    .write_i (req_write_i),
    .spl_i   (req_spl_i),
    .dac_i   (req_dac_i),
    .hr_i    (req_hr_i),
    .be_i    (req_be_i),
    .cmd_i   (req_cmd_i),
    .word_o  (cmd_word)
  );

  pci_req_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .go_i       (go),
    .is_read_i  (read_q),
    .need_pad_i (pad_q),
    .state_o    (state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_word_q <= '0;
      blen_q     <= '0;
      addr_q     <= '0;
      read_q     <= 1'b0;
      pad_q      <= 1'b0;
    end else if (start) begin
      cmd_word_q <= cmd_word;
      blen_q     <= req_blen_i;
      addr_q     <= req_addr_i;
      read_q     <= !req_write_i;
      // odd write needs padding unless single to a 32-bit agent
      pad_q      <= req_write_i && req_addr_i[ODD_BIT] && (agent64_i || !req_single_i);
    end
  end

  always_comb begin
    unique case (state)
      ST_CMD:  word_o = cmd_word_q;
      ST_BLEN: word_o = blen_q;
      ST_ALO:  word_o = {{HI_PAD{1'b0}}, addr_q[HALF_W-1:0]};
      ST_AHI:  word_o = {{HI_PAD{1'b0}}, addr_q[ADDR_W-1:HALF_W]};
      default: word_o = '0;
    endcase
  end

  assign word_en_o   = go && (state inside {ST_CMD, ST_BLEN, ST_ALO, ST_AHI});
  assign last_o      = word_en_o && (state == ST_AHI);
  assign data_en_o   = go && (state == ST_PAD);
  assign dbe_n_o     = {BE_W{state == ST_PAD}};
  assign busy_o      = (state != ST_IDLE);
  assign req_ready_o = (state == ST_IDLE);

  a_r1_en_needs_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_en_o || data_en_o) |-> (core_ready_i && !core_full_i));
  a_r1_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(core_ready_i && !core_full_i)) |=> $stable(word_o));
  a_r2_last_with_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> word_en_o);
  a_r8_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({word_en_o, data_en_o}) <= 1);
  a_r9_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (busy_o && !req_ready_o));
endmodule

// File: tb/pci_req_seq_tb_top.sv
module pci_req_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic agent64 = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_cmd = '0;
  logic [31:0] req_addr = '0;
  logic [17:0] req_blen = '0;
  logic [7:0]  req_be = '0;
  logic req_dac = 1'b0, req_hr = 1'b0, req_spl = 1'b0, req_single = 1'b0;
  logic core_ready = 1'b0, core_full = 1'b0;
  logic req_ready, word_en, last, data_en, busy;
  logic [17:0] word;
  logic [7:0]  dbe_n;

  int checks = 0, errors = 0;
  int stall_mode = 0;
  bit running = 1'b0;
  logic [19:0] expq[$];   // {is_pad, last, word}

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_req_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .agent64_i(agent64),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_cmd_i(req_cmd), .req_addr_i(req_addr), .req_blen_i(req_blen),
    .req_be_i(req_be), .req_dac_i(req_dac), .req_hr_i(req_hr),
    .req_spl_i(req_spl), .req_single_i(req_single),
    .core_ready_i(core_ready), .core_full_i(core_full),
    .word_o(word), .word_en_o(word_en), .last_o(last),
    .data_en_o(data_en), .dbe_n_o(dbe_n), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // handshake driver
  always @(posedge clk) begin
    #1;
    case (stall_mode)
      0: begin core_ready = 1'b1; core_full = 1'b0; end
      1: begin core_ready = ($urandom % 3) != 0; core_full = ($urandom % 4) == 0; end
      default: begin core_ready = 1'b0; core_full = 1'b1; end
    endcase
  end

  // reference model, compared every cycle
  always @(negedge clk) begin
    if (running) begin
      logic go;
      go = core_ready && !core_full;
      chk(busy == (expq.size() != 0), "R9 busy", busy, expq.size() != 0);
      chk(req_ready == (expq.size() == 0), "R9 ready", req_ready, expq.size() == 0);
      chk(!((word_en || data_en) && !go), "R1 strobe without room", {word_en, data_en}, 0);
      if (word_en || data_en) begin
        if (expq.size() == 0) chk(1'b0, "R2 unexpected word", word, 0);
        else begin
          logic [19:0] e;
          e = expq.pop_front();
          chk({data_en, last, word} == e, "R2 R3 R5 R6 R8 word", {data_en, last, word}, e);
          if (data_en) chk(dbe_n == 8'hFF, "R8 pad byte enables", dbe_n, 8'hFF);
        end
      end
      if (req_valid && req_ready) begin
        logic [17:0] cw;
        cw = {req_spl & ~req_write, req_dac, 3'b000, req_hr,
              req_write ? 8'h00 : req_be, req_cmd};
        expq.push_back({2'b00, cw});
        if (!req_write) expq.push_back({2'b00, req_blen});
        expq.push_back({2'b00, 2'b00, req_addr[15:0]});
        expq.push_back({2'b01, 2'b00, req_addr[31:16]});
        if (req_write && req_addr[2] && (agent64 || !req_single))
          expq.push_back({2'b10, 18'h0});
      end
    end
  end

  task automatic send(input bit wr, input logic [3:0] cmd, input logic [31:0] addr,
                      input logic [17:0] blen, input logic [7:0] be, input bit dac,
                      input bit hr, input bit spl, input bit single, input bit a64);
    @(posedge clk); #2;
    req_write = wr; req_cmd = cmd; req_addr = addr; req_blen = blen; req_be = be;
    req_dac = dac; req_hr = hr; req_spl = spl; req_single = single; agent64 = a64;
    req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #2;
    req_valid = 1'b0;
    while (busy) @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10 ready", req_ready, 1);
    chk(busy == 1'b0, "R10 busy", busy, 0);
    chk({word_en, data_en, last} == 3'b000, "R10 strobes", {word_en, data_en, last}, 0);
    rst_n = 1'b1;
    running = 1'b1;
    // R2 R3 R5 read, even address
    send(1'b0, 4'h6, 32'h1234_5670, 18'h2_0010, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R4 write ignores spl and be, even address: no pad (R7)
    send(1'b1, 4'h7, 32'hCAFE_0008, 18'h3_FFFF, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    // R7 R8 odd burst write
    send(1'b1, 4'h7, 32'h0000_1004, 18'h0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R7 odd single write, 32-bit agent: no pad
    send(1'b1, 4'h7, 32'hFFFF_FFFC, 18'h0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R7 odd single write, 64-bit agent: pad
    send(1'b1, 4'h7, 32'h8000_000C, 18'h0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    // R1 random stalls over mixed requests
    stall_mode = 1;
    for (int i = 0; i < 40; i++)
      send(i[0], 4'(i), $urandom, 18'($urandom), 8'($urandom), i[1], i[2], i[3],
           i[4], $urandom % 2 == 1);
    // R1 full stall: word held
    stall_mode = 2;
    send_nowait();
    repeat (6) begin
      @(negedge clk);
      chk(word_en == 1'b0 && busy == 1'b1, "R1 held under stall", {word_en, busy}, 2'b01);
    end
    stall_mode = 0;
    while (busy) @(posedge clk);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(expq.size() == 0, "R2 all words sent", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic send_nowait();
    @(posedge clk); #2;
    req_write = 1'b0; req_cmd = 4'hC; req_addr = 32'h0000_0040; req_blen = 18'h4;
    req_be = 8'h0F; req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask
endmodule